// File: doc/BRIEF.md
# Interrupt Coalescing Controller with Credits

This block is one interrupt resource. It turns event assertions on its input into one-cycle interrupt pulses. Three things limit the rate of those pulses: a countdown coalescing timer, a mask bit that can be set automatically on every send, and a pending flag that holds events which cannot be sent yet. A signed credit counter tracks interrupts sent minus interrupts acknowledged. Software acknowledges by writing an amount to subtract. The write does not overwrite the counter. When a write brings the counter to zero, all pending work is dropped.

Software reaches the block through a single-cycle write strobe and a combinational read port on a 32-byte window of 32-bit words. The countdown advances only in cycles where `tick_en` is high, so an external prescaler sets the timer unit (for example one microsecond). Writing the credit word can also clear the mask and restart the timer. Setting both of those flag bits re-arms the resource in one write.

Top module: `irq_coal_unit`

## Requirements
- R1: After reset: timer initial value 0, mask 1, mask-on-assert 0, credits 0, current timer 0, nothing pending, `irq_o` low.
- R2: With initial value 0 and mask 0, every cycle in which `evt_in` is high produces an `irq_o` pulse in the following cycle.
- R3: A send loads the current timer from the initial value. The timer then drops by one on each clock edge with `tick_en` high and holds while `tick_en` is low. No send happens in a cycle where the timer is nonzero, so with `tick_en` held high and events held high, sends are spaced N+1 cycles apart for initial value N.
- R4: An event that arrives while the timer is nonzero sets the pending flag. It is sent in the first cycle the timer reads zero, with no new event needed.
- R5: While the mask is 1 nothing is sent, but events still set the pending flag. Clearing the mask sends the held event one cycle after the write edge.
- R6: With mask-on-assert 1, every send sets the mask to 1. The automatic set wins over a software mask write in the same cycle.
- R7: Credits are a 16-bit two's-complement count. Each send adds 1. A write to offset 8 subtracts bits 15:0 of the written data, modulo 2^16. A send and a write in the same cycle are both applied.
- R8: A credit write that leaves the counter at 0 clears the pending flag and discards any event in that cycle, so no interrupt follows.
- R9: In a write to offset 8, bit 16 set clears the mask and bit 17 set reloads the current timer from the initial value. The reload takes priority over the tick decrement in that cycle.
- R10: A write to offset 0 stores the initial value clamped to at most 63.
- R11: Register map by byte address bits 4:2 (bits 1:0 ignored): 0 initial value, 4 mask (bit 0), 8 credits (bits 15:0; flag bits read 0), 12 mask-on-assert (bit 0), 16 current timer. Any other offset reads 0. Reads are combinational.
- R12: Writes to offset 16 and to reserved offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Countdown advance enable from the prescaler |
| evt_in | input | 1 | Event assertion, one event per high cycle |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | ADDR_W (5) | Byte address inside the 32-byte window |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for `reg_addr` |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Every state change lands on the clock edge that samples its stimulus. Register readback is combinational, so a value written at one edge can be read a quarter period after that edge. `irq_o` is registered: it rises after the edge that samples the event, or one edge after an unmask or the timer reaching zero. The bench drives inputs and samples outputs a quarter period after each rising edge. It counts edges from each stimulus, so a timer loaded with N is expected to reach zero N edges later and the next send is expected one edge after that. The coalescing sweep computes expected pulse counts and credit totals from this N+1 spacing.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
   // word offsets of the register window (byte address / 4)
   localparam int unsigned WRD_INIT = 0;
   localparam int unsigned WRD_MASK = 1;
   localparam int unsigned WRD_CRED = 2;
   localparam int unsigned WRD_MOA  = 3;
   localparam int unsigned WRD_CUR  = 4;
   // command bits carried in a credit-word write
   localparam int unsigned CMD_UNMASK_BIT = 16;
   localparam int unsigned CMD_RELOAD_BIT = 17;

   typedef struct packed {
      logic init_we;
      logic mask_we;
      logic cred_we;
      logic moa_we;
   } reg_we_t;
endpackage

// File: rtl/irq_coal_regs.sv
module irq_coal_regs
   import irq_coal_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned TMR_W  = 6,
   parameter int unsigned CRED_W = 16
) (
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [TMR_W-1:0]  init_i,
   input  logic              mask_i,
   input  logic [CRED_W-1:0] cred_i,
   input  logic              moa_i,
   input  logic [TMR_W-1:0]  cur_i,
   output reg_we_t           we_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned SEL_W = ADDR_W - 2;

   logic [SEL_W-1:0] sel;
   assign sel = addr_i[ADDR_W-1:2];

   always_comb begin
      we_o         = '0;
      we_o.init_we = wr_i && (sel == SEL_W'(WRD_INIT));
      we_o.mask_we = wr_i && (sel == SEL_W'(WRD_MASK));
      we_o.cred_we = wr_i && (sel == SEL_W'(WRD_CRED));
      we_o.moa_we  = wr_i && (sel == SEL_W'(WRD_MOA));
   end

   always_comb begin
      rdata_o = '0;
      case (sel)
         SEL_W'(WRD_INIT): rdata_o = DATA_W'(init_i);
         SEL_W'(WRD_MASK): rdata_o = DATA_W'(mask_i);
         SEL_W'(WRD_CRED): rdata_o = DATA_W'(cred_i);
         SEL_W'(WRD_MOA):  rdata_o = DATA_W'(moa_i);
         SEL_W'(WRD_CUR):  rdata_o = DATA_W'(cur_i);
         default:          rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/irq_coal_timer.sv
module irq_coal_timer #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned TMR_W    = 6,
   parameter int unsigned COAL_MAX = 63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              tick_i,
   input  logic              load_i,
   input  logic              reload_i,
   output logic [TMR_W-1:0]  init_o,
   output logic [TMR_W-1:0]  cur_o,
   output logic              zero_o
);
   logic [TMR_W-1:0] init_q, cur_q, init_clamped;

   // clamp variant: pure overflow test when the limit fills the field
   if (COAL_MAX == (2**TMR_W) - 1) begin : g_sat
      assign init_clamped = (|wdata_i[DATA_W-1:TMR_W]) ? TMR_W'(COAL_MAX)
                                                        : wdata_i[TMR_W-1:0];
   end else begin : g_cmp
      assign init_clamped = (wdata_i > DATA_W'(COAL_MAX)) ? TMR_W'(COAL_MAX)
                                                           : wdata_i[TMR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= '0;
      end else if (init_we_i) begin
         init_q <= init_clamped;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
      end else if (load_i || reload_i) begin
         cur_q <= init_q;
      end else if (tick_i && (cur_q != '0)) begin
         cur_q <= cur_q - 1'b1;
      end
   end

   assign init_o = init_q;
   assign cur_o  = cur_q;
   assign zero_o = (cur_q == '0);

   AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i || reload_i) |=> (cur_q == $past(init_q))); // R3
   AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !reload_i && tick_i && (cur_q != '0)) |=> (cur_q == $past(cur_q) - 1'b1)); // R3
   AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !reload_i && !tick_i) |=> $stable(cur_q)); // R3
   AST_INIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      init_we_i |=> (init_q <= TMR_W'(COAL_MAX))); // R10
endmodule

// File: rtl/irq_coal_credit.sv
module irq_coal_credit #(
   parameter int unsigned CRED_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_i,
   input  logic              dec_we_i,
   input  logic [CRED_W-1:0] dec_i,
   output logic [CRED_W-1:0] cred_o,
   output logic              zero_hit_o
);
   logic [CRED_W-1:0] cred_q, cred_d, sub;

   assign sub    = dec_we_i ? dec_i : '0;
   assign cred_d = cred_q + CRED_W'(inc_i) - sub;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cred_q <= '0;
      else        cred_q <= cred_d;
   end

   assign cred_o     = cred_q;
   assign zero_hit_o = dec_we_i && (cred_d == '0);

   AST_CRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !dec_we_i) |=> $stable(cred_q)); // R7
   AST_CRED_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !dec_we_i) |=> (cred_q == CRED_W'($past(cred_q) + 1'b1))); // R7
endmodule

// File: rtl/irq_coal_unit.sv
module irq_coal_unit
   import irq_coal_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned TMR_W    = 6,
   parameter int unsigned COAL_MAX = 63,
   parameter int unsigned CRED_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              evt_in,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o
);
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must cover the 32-byte window");
   end
   if (DATA_W < CMD_RELOAD_BIT + 1 || DATA_W > 32) begin : g_bad_data
      $error("DATA_W must hold the command bits and stay within 32");
   end
   if (TMR_W < 1 || TMR_W >= DATA_W) begin : g_bad_tmr
      $error("TMR_W out of range");
   end
   if (COAL_MAX >= 2**TMR_W) begin : g_bad_max
      $error("COAL_MAX does not fit TMR_W");
   end
   if (CRED_W < 2 || CRED_W > CMD_UNMASK_BIT) begin : g_bad_cred
      $error("CRED_W must sit below the command bits");
   end

   reg_we_t           we;
   logic [TMR_W-1:0]  init_v, cur_v;
   logic [CRED_W-1:0] cred_v;
   logic              tmr_zero, cred_zero_hit;
   logic              mask_q, moa_q, pend_q, irq_q;
   logic              send, want;
   logic              cmd_unmask, cmd_reload;

   assign cmd_unmask = we.cred_we && reg_wdata[CMD_UNMASK_BIT];
   assign cmd_reload = we.cred_we && reg_wdata[CMD_RELOAD_BIT];

   irq_coal_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMR_W(TMR_W), .CRED_W(CRED_W)
   ) u_regs (
      .wr_i(reg_wr), .addr_i(reg_addr),
      .init_i(init_v), .mask_i(mask_q), .cred_i(cred_v),
      .moa_i(moa_q), .cur_i(cur_v),
      .we_o(we), .rdata_o(reg_rdata)
   );

   irq_coal_timer #(
      .DATA_W(DATA_W), .TMR_W(TMR_W), .COAL_MAX(COAL_MAX)
   ) u_timer (
      .clk(clk), .rst_n(rst_n),
      .init_we_i(we.init_we), .wdata_i(reg_wdata),
      .tick_i(tick_en), .load_i(send), .reload_i(cmd_reload),
      .init_o(init_v), .cur_o(cur_v), .zero_o(tmr_zero)
   );

   irq_coal_credit #(
      .CRED_W(CRED_W)
   ) u_cred (
      .clk(clk), .rst_n(rst_n),
      .inc_i(send), .dec_we_i(we.cred_we), .dec_i(reg_wdata[CRED_W-1:0]),
      .cred_o(cred_v), .zero_hit_o(cred_zero_hit)
   );

   // send decision: something to send, unmasked, timer expired
   assign want = pend_q || evt_in;
   assign send = want && !mask_q && tmr_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (cred_zero_hit || send) begin
         pend_q <= 1'b0;
      end else if (evt_in) begin
         pend_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b1;
      end else if (send && moa_q) begin
         mask_q <= 1'b1;
      end else if (we.mask_we) begin
         mask_q <= reg_wdata[0];
      end else if (cmd_unmask) begin
         mask_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         moa_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (we.moa_we) moa_q <= reg_wdata[0];
         irq_q <= send;
      end
   end

   assign irq_o = irq_q;

   AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |=> !irq_o); // R5
   AST_TIMER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_zero |=> !irq_o); // R3
   AST_AUTO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && $past(moa_q)) |-> mask_q); // R6
   AST_CRED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      cred_zero_hit |=> !pend_q); // R8
   AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_in && mask_q && !cred_zero_hit) |=> pend_q); // R5
endmodule

// File: tb/sim_irq_coal_unit.sv
module sim_irq_coal_unit;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        evt_in = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   irq_coal_unit u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .evt_in(evt_in),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #(CLK_P/4);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      cyc();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v;
      int cnt;
      repeat (3) @(posedge clk);
      #(CLK_P/4);
      rst_n = 1'b1;
      cyc();

      // R1 reset state
      rd(0, v);  chk("R1 init", v, 0);
      rd(4, v);  chk("R1 mask", v, 1);
      rd(8, v);  chk("R1 credits", v, 0);
      rd(12, v); chk("R1 moa", v, 0);
      rd(16, v); chk("R1 cur", v, 0);
      chk("R1 irq", irq_o, 0);

      // R11 reserved offsets, ignored low address bits
      rd(20, v); chk("R11 rsvd20", v, 0);
      rd(28, v); chk("R11 rsvd28", v, 0);
      rd(6, v);  chk("R11 low bits ignored", v, 1);

      // R10 clamp
      wr(0, 100);          rd(0, v); chk("R10 clamp 100", v, 63);
      wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R10 clamp max", v, 63);
      wr(0, 5);            rd(0, v); chk("R10 in range", v, 5);
      wr(0, 0);

      // R5 masked event is held, sent after unmask
      evt_in = 1'b1; cyc(); evt_in = 1'b0;
      chk("R5 masked no irq", irq_o, 0);
      cyc(); chk("R5 still masked", irq_o, 0);
      wr(4, 0); chk("R5 write edge", irq_o, 0);
      cyc(); chk("R5 pending sent", irq_o, 1);
      cyc(); chk("R5 single pulse", irq_o, 0);
      rd(8, v); chk("R7 credit after send", v, 1);

      // R2 no coalescing: every event sends
      cnt = 0;
      evt_in = 1'b1;
      for (int i = 0; i < 3; i++) begin cyc(); cnt += irq_o; end
      evt_in = 1'b0;
      chk("R2 every event", cnt, 3);
      rd(8, v); chk("R7 credit count", v, 4);

      // R6 mask on assert
      wr(12, 1);
      evt_in = 1'b1; cyc(); evt_in = 1'b0;
      chk("R6 send", irq_o, 1);
      rd(4, v); chk("R6 auto mask", v, 1);
      evt_in = 1'b1; cyc(); evt_in = 1'b0;
      chk("R6 masked after", irq_o, 0);
      wr(12, 0);

      // R9 unmask command, pending kept (credits 5 not zero)
      wr(8, 32'h0001_0000);
      rd(4, v); chk("R9 unmask flag", v, 0);
      rd(8, v); chk("R9 credits untouched", v, 5);
      cyc(); chk("R9 pending sent", irq_o, 1);

      // R7 send and decrement in the same cycle, signed values
      evt_in = 1'b1; wr(8, 3); evt_in = 1'b0;
      chk("R7 same-cycle irq", irq_o, 1);
      rd(8, v); chk("R7 same-cycle credit", v, 4);
      wr(8, 32'h0000_FFFF); rd(8, v); chk("R7 minus one", v, 5);
      wr(8, 7);             rd(8, v); chk("R7 negative", v, 32'hFFFE);
      wr(8, 32'h0000_FFFE); rd(8, v); chk("R7 back to zero", v, 0);

      // R3 timer behaviour
      wr(0, 10);
      evt_in = 1'b1; cyc(); evt_in = 1'b0;
      chk("R3 send at zero", irq_o, 1);
      rd(16, v); chk("R3 load", v, 10);
      repeat (3) cyc();
      rd(16, v); chk("R3 hold without tick", v, 10);
      tick_en = 1'b1;
      repeat (3) cyc();
      rd(16, v); chk("R3 decrement", v, 7);
      evt_in = 1'b1; cyc(); evt_in = 1'b0;
      chk("R3 blocked while busy", irq_o, 0);
      wr(8, 32'h0002_0000);
      rd(16, v); chk("R9 reload", v, 10);
      wr(16, 3);
      rd(16, v); chk("R12 cur write ignored", v, 9);
      cnt = 0;
      for (int i = 0; i < 8; i++) begin cyc(); cnt += irq_o; end
      wr(24, 32'hFFFF_FFFF); cnt += irq_o;
      chk("R4 no send before zero", cnt, 0);
      rd(0, v);  chk("R12 init kept", v, 10);
      rd(4, v);  chk("R12 mask kept", v, 0);
      rd(12, v); chk("R12 moa kept", v, 0);
      cyc(); chk("R4 pending sent at zero", irq_o, 1);

      // R3/R8 sweep of initial values with events held high
      for (int n = 0; n < 8; n++) begin
         int w, expc;
         w = 20;
         expc = (w - 1) / (n + 1) + 1;
         if (n > 0 && (w % (n + 1)) == 0) expc++;
         wr(4, 1);
         rd(8, v);
         wr(8, {16'h0, v[15:0]});
         repeat (70) cyc();
         wr(0, n);
         wr(4, 0);
         cnt = 0;
         evt_in = 1'b1;
         for (int e = 0; e < w; e++) begin cyc(); cnt += irq_o; end
         evt_in = 1'b0;
         wr(4, 1); cnt += irq_o;
         chk($sformatf("R3 spacing n=%0d", n), cnt, expc);
         rd(8, v); chk($sformatf("R7 sweep credits n=%0d", n), v, expc);
         wr(8, expc);
         rd(8, v); chk("R8 credit zero", v, 0);
         wr(8, 32'h0001_0000);
         cnt = 0;
         for (int e = 0; e < 3 * n + 5; e++) begin cyc(); cnt += irq_o; end
         chk($sformatf("R8 pending dropped n=%0d", n), cnt, 0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule